// File: doc/BRIEF.md
# Resynchronizable Sample Clock Divider

This block turns a carrier clock into the slower bit-sampling clock that a contactless-card receiver uses to sample its demodulated data. The divide ratio is picked at runtime by a 3-bit index into a fixed table of powers of two. The output runs at a 50% duty cycle: it is high for the first half of each divisor period and low for the second half.

The phase of the divider can be forced back to a known point. Three events do this. The first is a one-cycle software trigger strobe, which firmware also pulses each time it arms a new receive buffer. The second is the rising edge of the sync enable. The third, while sync is enabled, is any edge (rising or falling) on the demodulated data line, which is first passed through a synchronizer. On such a phase reset, the counter is loaded from a phase offset input, masked to the range of the selected divisor. The divisor selected at that moment takes effect at once. At other times, a new divisor index is taken only when the count wraps.

Top module: `sample_clk_divider`

## Requirements
- R1: After reset the count is 0 and the active index is 6 (divide by 32), so the output is high for 16 cycles and then low for 16 cycles, repeating.
- R2: Index encoding: 0→8192, 1→2048, 2→1024, 3→512, 4→128, 5→64, 6→32, 7→16. For any active divisor D, the output is high while the count is below D/2 and low from D/2 to D-1. The count then wraps to 0.
- R3: Without a phase reset, a change of `div_sel` takes effect only at the next wrap. Until then the current period completes with the old divisor.
- R4: A one-cycle `sw_trig` pulse restarts the count at the (masked) phase offset in the next cycle, from any point of the period.
- R5: On every phase reset the counter is loaded with `phase_ofs` ANDed with D-1 of the newly selected divisor. The output then continues from that point.
- R6: A 0→1 change of `sync_en` performs a phase reset in the same clock edge that first sees the high level.
- R7: While `sync_en` is high, each rising or falling edge of `data_in` performs a phase reset at the third rising clock edge after the change, counting the edge that first samples it.
- R8: While `sync_en` is low, edges of `data_in` have no effect on the output.
- R9: A phase reset applies the current `div_sel` at once. If it falls in the same cycle as a wrap, the phase reset wins and the count is loaded from the offset, not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | 3 | Divisor table index |
| phase_ofs | input | 13 | Counter preload used on a phase reset |
| sync_en | input | 1 | Enables resync on data edges; its rising edge resyncs |
| data_in | input | 1 | Demodulated data line (asynchronous) |
| sw_trig | input | 1 | One-cycle software phase-reset strobe |
| sclk_out | output | 1 | Divided sample clock, 50% duty |

## Verification
Two functions can coincide: the natural wrap at the end of a period and a phase reset, each of which would load the counter and the divisor index. The bench provokes this by running a divide-by-16 period from a known start. It pulses the software trigger, together with a new index, in exactly the cycle where the count sits at 15. Only a resync that wins yields the offset-shifted pattern of the new divisor. A wrap that wins would restart from zero, so the following output sequence shows which one prevailed.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;
  localparam int IDX_W = 3;
  localparam int CNT_W = 13;

  // log2 of the divisor selected by an index
  function automatic int div_shift(logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return 13;
      3'd1:    return 11;
      3'd2:    return 10;
      3'd3:    return 9;
      3'd4:    return 7;
      3'd5:    return 6;
      3'd6:    return 5;
      default: return 4;
    endcase
  endfunction

  // terminal count (divisor - 1)
  function automatic logic [CNT_W-1:0] div_mask(logic [IDX_W-1:0] idx);
    return CNT_W'((1 << div_shift(idx)) - 1);
  endfunction

  // true during the high half of the period
  function automatic logic high_phase(logic [CNT_W-1:0] cnt, logic [IDX_W-1:0] idx);
    return int'(cnt) < (1 << (div_shift(idx) - 1));
  endfunction
endpackage

// File: rtl/sclkdiv_edge_sync.sv
module sclkdiv_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_in,
  output logic data_edge
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= data_in;
  end

  generate
    for (genvar g = 1; g <= LAST; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign data_edge = chain_q[LAST] ^ chain_q[LAST-1];
endmodule

// File: rtl/sclkdiv_resync_ctl.sv
module sclkdiv_resync_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_en,
  input  logic data_edge,
  input  logic sw_trig,
  output logic en_rise,
  output logic resync
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= sync_en;
  end

  assign en_rise = sync_en & ~en_q;
  assign resync  = sw_trig | en_rise | (sync_en & data_edge);
endmodule

// File: rtl/sclkdiv_core.sv
module sclkdiv_core
  import sclkdiv_pkg::*;
#(
  parameter logic [IDX_W-1:0] RST_IDX = 3'd6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync,
  input  logic [IDX_W-1:0] sel,
  input  logic [CNT_W-1:0] ofs,
  output logic [CNT_W-1:0] cnt,
  output logic [IDX_W-1:0] idx,
  output logic             wrap,
  output logic             sclk
);
  assign wrap = (cnt == div_mask(idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      idx <= RST_IDX;
    end else if (resync) begin
      cnt <= ofs & div_mask(sel);
      idx <= sel;
    end else if (wrap) begin
      cnt <= '0;
      idx <= sel;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign sclk = high_phase(cnt, idx);
endmodule

// File: rtl/sample_clk_divider.sv
module sample_clk_divider
  import sclkdiv_pkg::*;
#(
  parameter logic [IDX_W-1:0] RST_IDX     = 3'd6,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] div_sel,
  input  logic [CNT_W-1:0] phase_ofs,
  input  logic             sync_en,
  input  logic             data_in,
  input  logic             sw_trig,
  output logic             sclk_out
);
  logic             data_edge_w;
  logic             en_rise_w;
  logic             resync_w;
  logic             wrap_w;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;

  sclkdiv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .data_edge(data_edge_w)
  );

  sclkdiv_resync_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .data_edge(data_edge_w),
    .sw_trig(sw_trig), .en_rise(en_rise_w), .resync(resync_w)
  );

  sclkdiv_core #(.RST_IDX(RST_IDX)) u_core (
    .clk(clk), .rst_n(rst_n), .resync(resync_w), .sel(div_sel),
    .ofs(phase_ofs), .cnt(cnt_q), .idx(idx_q), .wrap(wrap_w), .sclk(sclk_out)
  );
endmodule

// File: rtl/sample_clk_divider_chk.sv
module sample_clk_divider_chk
  import sclkdiv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] div_sel,
  input logic [CNT_W-1:0] phase_ofs,
  input logic             sync_en,
  input logic             sw_trig,
  input logic             sclk_out,
  input logic             resync_w,
  input logic             wrap_w,
  input logic [CNT_W-1:0] cnt_q,
  input logic [IDX_W-1:0] idx_q
);
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_mask(idx_q)); // R2

  AST_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_w && !resync_w) |=> sclk_out); // R2

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_w && !resync_w) |=> (idx_q == $past(idx_q))); // R3

  AST_SWTRIG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trig |=> (cnt_q == ($past(phase_ofs) & div_mask($past(div_sel))))); // R4

  AST_EN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && !$past(sync_en)) |-> resync_w); // R6

  AST_NO_DATA_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en && !sw_trig) |-> !resync_w); // R8

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    resync_w |=> (idx_q == $past(div_sel))); // R9
endmodule

bind sample_clk_divider sample_clk_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .phase_ofs(phase_ofs),
  .sync_en(sync_en), .sw_trig(sw_trig), .sclk_out(sclk_out),
  .resync_w(resync_w), .wrap_w(wrap_w), .cnt_q(cnt_q), .idx_q(idx_q)
);

// File: tb/tb_sample_clk_divider.sv
module tb_sample_clk_divider;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  div_sel = 3'd6;
  logic [12:0] phase_ofs = '0;
  logic        sync_en = 1'b0;
  logic        data_in = 1'b0;
  logic        sw_trig = 1'b0;
  logic        sclk_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sample_clk_divider dut (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .phase_ofs(phase_ofs),
    .sync_en(sync_en), .data_in(data_in), .sw_trig(sw_trig), .sclk_out(sclk_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected output for n samples starting at count 'start' of divisor 'dv'
  task automatic run_check(int dv, int start, int n, string tag);
    int bad = 0;
    int bad_act = 0;
    int bad_exp = 0;
    for (int i = 0; i < n; i++) begin
      int ph = (start + i) % dv;
      logic e = (ph < dv / 2);
      if (sclk_out !== e && bad == 0) begin
        bad_act = int'(sclk_out);
        bad_exp = int'(e);
      end
      if (sclk_out !== e) bad++;
      @(negedge clk);
    end
    check(bad == 0, tag, bad_act, bad_exp);
  endtask

  task automatic trig(int o);
    phase_ofs = 13'(o);
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
  endtask

  task automatic t_reset;
    check(sclk_out === 1'b1, "R1 out after reset", int'(sclk_out), 1);
    run_check(32, 0, 64, "R1 reset divide by 32");
  endtask

  task automatic t_div_change;
    run_check(32, 0, 10, "R3 before change");
    div_sel = 3'd7;
    run_check(32, 10, 22, "R3 old period completes");
    run_check(16, 0, 48, "R3 new divisor after wrap");
  endtask

  task automatic t_wrap_collide;
    run_check(16, 0, 15, "R9 lead-in");
    div_sel = 3'd4;
    trig(7);
    run_check(128, 7, 256, "R9 resync wins over wrap");
  endtask

  task automatic t_swtrig;
    div_sel = 3'd6;
    trig(0);
    run_check(32, 0, 11, "R4 aligned");
    trig(0);
    run_check(32, 0, 64, "R4 restart mid period");
  endtask

  task automatic t_offset;
    div_sel = 3'd4;
    trig(40);
    run_check(128, 40, 256, "R5 offset 40");
    div_sel = 3'd7;
    trig(100);
    run_check(16, 4, 32, "R5 offset masked");
  endtask

  task automatic t_sweep;
    div_sel = 3'd5;
    trig(0);
    run_check(64, 0, 128, "R2 divide by 64");
    div_sel = 3'd0;
    trig(0);
    run_check(8192, 0, 16384, "R2 divide by 8192");
    div_sel = 3'd3;
    trig(0);
    run_check(512, 0, 1024, "R2 divide by 512");
  endtask

  task automatic t_en_rise;
    div_sel = 3'd5;
    phase_ofs = 13'd20;
    sync_en = 1'b1;
    @(negedge clk);
    run_check(64, 20, 128, "R6 enable resync");
  endtask

  task automatic t_data_edges;
    phase_ofs = 13'd9;
    data_in = 1'b1;
    repeat (3) @(negedge clk);
    run_check(64, 9, 128, "R7 rising data edge");
    phase_ofs = 13'd33;
    data_in = 1'b0;
    repeat (3) @(negedge clk);
    run_check(64, 33, 128, "R7 falling data edge");
  endtask

  task automatic t_data_ignored;
    sync_en = 1'b0;
    trig(0);
    phase_ofs = 13'd50;
    for (int i = 0; i < 6; i++) begin
      data_in = ~data_in;
      run_check(64, 5 * i, 5, "R8 edges ignored");
    end
    run_check(64, 30, 40, "R8 tail");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_div_change;
    t_wrap_collide;
    t_swtrig;
    t_offset;
    t_sweep;
    t_en_rise;
    t_data_edges;
    t_data_ignored;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule